// File: doc/BRIEF.md
# SPI Card Initialization Sequencer

This block is host-side control logic that brings a memory card up in SPI mode. When `start` is pulsed, it first sends a run of idle bytes with chip select released and the data line held at all ones. This gives the card the minimum number of warm-up clocks. Next it sends the software reset command. It then sends the operating-condition command again and again until the card's one-byte reply shows that the idle flag has cleared. After every reply, and also after a reply that never arrives, it sends one more all-ones byte with chip select released. That byte gives the card the eight trailing clocks it needs before the clock may stop.

The block does not shift bits itself. It drives a byte-wide SPI transmit/receive engine through a level request and a one-cycle done pulse. For every byte, the engine shifts out `xfer_tx` and returns the byte it received on `xfer_rx`. It also drives the chip select pin from `xfer_cs_n`. The outcome is reported on `ready` or `err`. A parameter sets the maximum number of operating-condition attempts.

Top module: `spi_card_init`

## Requirements
- R1: After reset, `busy`, `ready`, `err` and `xfer_req` are 0 and `xfer_cs_n` is 1.
- R2: After `start`, the first ceil(WARM_CLKS/8) bytes (10 by default) are 0xFF with `xfer_cs_n` = 1. No byte with chip select low comes before them.
- R3: The reset command is sent with `xfer_cs_n` = 0 as the six bytes 0x40, 0x00, 0x00, 0x00, 0x00, 0x95.
- R4: After each command, the block sends 0xFF polling bytes with chip select low. It takes the first received byte whose bit 7 is 0 as the reply. If none of POLL_BYTES (8) polling bytes has bit 7 clear, the block ends in `err`.
- R5: Every reply, and every polling timeout, is followed by exactly one 0xFF byte with `xfer_cs_n` = 1. Only then does the next command start or does `ready`/`err` rise.
- R6: After a valid reset-command reply, the operating-condition command is sent as 0x41, 0x00, 0x00, 0x00, 0x00, 0xF9 with chip select low.
- R7: The operating-condition command is resent while reply bit 0 (idle) is 1. `ready` rises once a reply has bit 0 = 0 and bits 6..1 = 0.
- R8: If MAX_TRIES operating-condition replies all have the idle bit set, the block ends in `err` after exactly MAX_TRIES such commands.
- R9: A reply with any of bits 6..1 set, to either command, ends the sequence in `err` with no further command sent.
- R10: `start` has no effect while `busy` is 1. From idle, `ready` or `err` it restarts the whole sequence.
- R11: `xfer_req` stays high and `xfer_tx` stays stable until `xfer_done` is seen.
- R12: While `ready` or `err` is 1, no byte is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the initialization sequence |
| busy | output | 1 | Sequence in progress |
| ready | output | 1 | Card left the idle state |
| err | output | 1 | Timeout, error reply or retry limit reached |
| xfer_req | output | 1 | Byte transfer request to the SPI engine |
| xfer_tx | output | 8 | Byte to send |
| xfer_cs_n | output | 1 | Chip select level for this byte, active low |
| xfer_done | input | 1 | One-cycle pulse: byte finished |
| xfer_rx | input | 8 | Byte received, valid with `xfer_done` |

## Verification
Each error in the internal byte counter or state shows up at once in the byte stream the engine sees. Examples are a short warm-up run, a wrong command byte or CRC, chip select low on the tail byte, or a missing tail byte, and each is caught within one byte transfer of the mistake. A wrong reply decision shows as a wrong number of operating-condition commands, or as the wrong one of `ready`/`err`, within about ten transfers. A broken handshake shows as `xfer_tx` changing while a request is pending, in the same cycle.

// File: rtl/spi_card_init.sv
module spi_card_init #(
  parameter int WARM_CLKS  = 74,
  parameter int POLL_BYTES = 8,
  parameter int MAX_TRIES  = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       busy,
  output logic       ready,
  output logic       err,
  output logic       xfer_req,
  output logic [7:0] xfer_tx,
  output logic       xfer_cs_n,
  input  logic       xfer_done,
  input  logic [7:0] xfer_rx
);
  localparam int WARM_BYTES = (WARM_CLKS + 7) / 8;
  localparam int CNT_TOP = (WARM_BYTES > POLL_BYTES) ? WARM_BYTES : POLL_BYTES;
  localparam int CW = $clog2(((CNT_TOP > 6) ? CNT_TOP : 6) + 1);
  localparam int TW = $clog2(MAX_TRIES + 1);

  typedef enum logic [2:0] {S_IDLE, S_WARM, S_CMD, S_RESP, S_TAIL, S_READY, S_FAIL} st_t;
  typedef enum logic [1:0] {N_OPCOND, N_DONE, N_FAIL} nxt_t;

  st_t           st;
  nxt_t          nxt;
  logic          req_q;
  logic          is_op;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tries;

  assign busy      = (st == S_WARM) || (st == S_CMD) || (st == S_RESP) || (st == S_TAIL);
  assign ready     = (st == S_READY);
  assign err       = (st == S_FAIL);
  assign xfer_req  = req_q;
  assign xfer_cs_n = !((st == S_CMD) || (st == S_RESP));

  always_comb begin
    xfer_tx = 8'hFF;
    if (st == S_CMD) begin
      if (cnt == CW'(0))      xfer_tx = is_op ? 8'h41 : 8'h40;
      else if (cnt == CW'(5)) xfer_tx = is_op ? 8'hF9 : 8'h95;
      else                    xfer_tx = 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      nxt   <= N_FAIL;
      req_q <= 1'b0;
      is_op <= 1'b0;
      cnt   <= '0;
      tries <= '0;
    end else if (start && !busy) begin
      st    <= S_WARM;
      req_q <= 1'b0;
      is_op <= 1'b0;
      cnt   <= '0;
      tries <= '0;
    end else if (busy) begin
      if (!req_q) begin
        req_q <= 1'b1;
        if (st == S_CMD && cnt == CW'(0) && is_op) tries <= tries + TW'(1);
      end else if (xfer_done) begin
        req_q <= 1'b0;
        case (st)
          S_WARM:
            if (cnt == CW'(WARM_BYTES - 1)) begin
              st  <= S_CMD;
              cnt <= '0;
            end else cnt <= cnt + CW'(1);
          S_CMD:
            if (cnt == CW'(5)) begin
              st  <= S_RESP;
              cnt <= '0;
            end else cnt <= cnt + CW'(1);
          S_RESP:
            if (!xfer_rx[7]) begin
              st <= S_TAIL;
              if (|xfer_rx[6:1])             nxt <= N_FAIL;
              else if (!is_op)               nxt <= N_OPCOND;
              else if (!xfer_rx[0])          nxt <= N_DONE;
              else if (tries == TW'(MAX_TRIES)) nxt <= N_FAIL;
              else                           nxt <= N_OPCOND;
            end else if (cnt == CW'(POLL_BYTES - 1)) begin
              st  <= S_TAIL;
              nxt <= N_FAIL;
            end else cnt <= cnt + CW'(1);
          S_TAIL:
            case (nxt)
              N_OPCOND: begin
                st    <= S_CMD;
                cnt   <= '0;
                is_op <= 1'b1;
              end
              N_DONE:  st <= S_READY;
              default: st <= S_FAIL;
            endcase
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_done) |=> (xfer_req && $stable(xfer_tx)));

  p_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ready || err) |-> !xfer_req);

  p_tries_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tries <= TW'(MAX_TRIES));

  p_poll_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RESP) |-> (cnt < CW'(POLL_BYTES)));

  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !xfer_done) |=> busy);

  p_end_after_tail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ready) || $rose(err)) |-> ($past(st) == S_TAIL));
endmodule

// File: tb/spi_card_init_tb.sv
module spi_card_init_tb;
  localparam int TRIES = 5;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic busy, ready, err, xfer_req, xfer_cs_n;
  logic [7:0] xfer_tx;
  logic xfer_done = 0;
  logic [7:0] xfer_rx = 8'hFF;

  always #10 clk = ~clk;

  spi_card_init #(.WARM_CLKS(74), .POLL_BYTES(8), .MAX_TRIES(TRIES)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .ready(ready), .err(err),
    .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_cs_n(xfer_cs_n),
    .xfer_done(xfer_done), .xfer_rx(xfer_rx));

  int n_chk = 0, n_bad = 0;

  // card configuration, written only by the initial block
  int   cfg_delay0 = 1, cfg_delay1 = 1, cfg_idle = 0;
  logic [7:0] cfg_r0 = 8'h01, cfg_r1 = 8'h00;
  logic clr = 0;

  // engine + card model state and log
  logic eng_busy = 0;
  int   eng_cnt = 0;
  logic [7:0] lat_tx;
  logic lat_cs;
  logic [7:0] cb [6];
  int   cidx = 0, wait_n = 0, idle_left = 0;
  logic any_cmd = 0, tail_exp = 0;
  logic [7:0] resp_v = 8'h00, reply = 8'hFF;
  int   warm_n = 0, cmd0_n = 0, cmd1_n = 0, frame_bad = 0, tail_ok = 0, tail_bad = 0;
  int   bytes_n = 0, unstable = 0;
  logic [7:0] prev_tx = 8'hFF;
  logic prev_pend = 0;

  always @(posedge clk) begin
    if (clr) begin
      warm_n = 0; cmd0_n = 0; cmd1_n = 0; frame_bad = 0; tail_ok = 0; tail_bad = 0;
      bytes_n = 0; unstable = 0; cidx = 0; any_cmd = 0; tail_exp = 0; idle_left = cfg_idle;
    end
    if (prev_pend && xfer_req && xfer_tx != prev_tx) unstable = unstable + 1;
    prev_pend = xfer_req && !xfer_done;
    prev_tx = xfer_tx;
    if (xfer_done) begin
      xfer_done <= 1'b0;
    end else if (!eng_busy && xfer_req) begin
      eng_busy <= 1'b1;
      eng_cnt = 2;
      lat_tx = xfer_tx;
      lat_cs = xfer_cs_n;
      bytes_n = bytes_n + 1;
      reply = 8'hFF;
      if (tail_exp) begin
        tail_exp = 0;
        if (lat_cs && lat_tx == 8'hFF) tail_ok = tail_ok + 1; else tail_bad = tail_bad + 1;
      end else if (lat_cs) begin
        if (cidx == 6) begin
          cidx = 0;
          if (lat_tx == 8'hFF) tail_ok = tail_ok + 1; else tail_bad = tail_bad + 1;
        end else if (!any_cmd) begin
          warm_n = warm_n + 1;
          if (lat_tx != 8'hFF) frame_bad = frame_bad + 1;
        end else tail_bad = tail_bad + 1;
      end else if (cidx < 6) begin
        any_cmd = 1;
        cb[cidx] = lat_tx;
        cidx = cidx + 1;
        if (cidx == 6) begin
          if (cb[1] != 0 || cb[2] != 0 || cb[3] != 0 || cb[4] != 0) frame_bad = frame_bad + 1;
          if (cb[0] == 8'h40) begin
            cmd0_n = cmd0_n + 1;
            if (cb[5] != 8'h95) frame_bad = frame_bad + 1;
            wait_n = cfg_delay0; resp_v = cfg_r0;
          end else if (cb[0] == 8'h41) begin
            cmd1_n = cmd1_n + 1;
            if (cb[5] != 8'hF9) frame_bad = frame_bad + 1;
            wait_n = cfg_delay1;
            if (idle_left > 0) begin resp_v = 8'h01; idle_left = idle_left - 1; end
            else resp_v = cfg_r1;
          end else frame_bad = frame_bad + 1;
        end
      end else begin
        if (lat_tx != 8'hFF) frame_bad = frame_bad + 1;
        if (wait_n > 0) wait_n = wait_n - 1;
        else begin reply = resp_v; cidx = 0; tail_exp = 1; end
      end
    end else if (eng_busy) begin
      if (eng_cnt == 0) begin
        xfer_done <= 1'b1;
        xfer_rx <= reply;
        eng_busy <= 1'b0;
      end else eng_cnt = eng_cnt - 1;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_seq(input int cyc_start_busy);
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0; start = 1;
    @(negedge clk); start = 0;
    if (cyc_start_busy > 0) begin
      repeat (cyc_start_busy) @(negedge clk);
      chk(busy, "R10 busy before ignored start", busy, 1);
      start = 1; @(negedge clk); start = 0;
    end
    for (int i = 0; i < 20000 && !(ready || err); i++) @(negedge clk);
    chk(ready || err, "R7 sequence completes", ready || err, 1);
  endtask

  task automatic t_reset;
    chk(!busy && !ready && !err && !xfer_req && xfer_cs_n, "R1 reset state",
        {busy, ready, err, xfer_req, xfer_cs_n}, 1);
  endtask

  task automatic t_basic;
    cfg_delay0 = 1; cfg_delay1 = 2; cfg_idle = 2; cfg_r0 = 8'h01; cfg_r1 = 8'h00;
    run_seq(0);
    chk(ready && !err, "R7 ready after idle clears", ready, 1);
    chk(warm_n == 10, "R2 warm byte count", warm_n, 10);
    chk(cmd0_n == 1, "R3 one reset command", cmd0_n, 1);
    chk(cmd1_n == 3, "R6 opcond command count", cmd1_n, 3);
    chk(frame_bad == 0, "R3 command frames", frame_bad, 0);
    chk(tail_ok == 4 && tail_bad == 0, "R5 tail bytes", tail_ok, 4);
    chk(unstable == 0, "R11 tx stable under request", unstable, 0);
    begin
      int b0 = bytes_n;
      repeat (60) @(negedge clk);
      chk(bytes_n == b0 && !xfer_req, "R12 quiet when ready", bytes_n, b0);
    end
  endtask

  task automatic t_poll_edge;
    cfg_delay0 = 7; cfg_delay1 = 7; cfg_idle = 0; cfg_r0 = 8'h01; cfg_r1 = 8'h00;
    run_seq(0);
    chk(ready, "R4 reply on last poll byte accepted", ready, 1);
    chk(cmd1_n == 1, "R4 single opcond", cmd1_n, 1);
  endtask

  task automatic t_timeout;
    cfg_delay0 = 8; cfg_delay1 = 1; cfg_idle = 0; cfg_r0 = 8'h01;
    run_seq(0);
    chk(err && !ready, "R4 no reply gives err", err, 1);
    chk(cmd1_n == 0, "R4 no opcond after timeout", cmd1_n, 0);
    chk(tail_ok == 1 && tail_bad == 0, "R5 tail after timeout", tail_ok, 1);
    begin
      int b0 = bytes_n;
      repeat (60) @(negedge clk);
      chk(bytes_n == b0, "R12 quiet when err", bytes_n, b0);
    end
  endtask

  task automatic t_limit;
    cfg_delay0 = 0; cfg_delay1 = 0; cfg_idle = 1000; cfg_r0 = 8'h01;
    run_seq(0);
    chk(err, "R8 retry limit gives err", err, 1);
    chk(cmd1_n == TRIES, "R8 opcond attempts", cmd1_n, TRIES);
    chk(tail_ok == TRIES + 1, "R5 tail per reply", tail_ok, TRIES + 1);
  endtask

  task automatic t_errbits;
    cfg_delay0 = 2; cfg_delay1 = 1; cfg_idle = 0; cfg_r0 = 8'h01; cfg_r1 = 8'h04;
    run_seq(0);
    chk(err, "R9 error bit in reply", err, 1);
    chk(cmd1_n == 1, "R9 no retry after error bit", cmd1_n, 1);
    cfg_r0 = 8'h05; cfg_r1 = 8'h00;
    run_seq(0);
    chk(err && cmd1_n == 0, "R9 error bit in reset reply", cmd1_n, 0);
  endtask

  task automatic t_busy_start;
    cfg_delay0 = 1; cfg_delay1 = 1; cfg_idle = 1; cfg_r0 = 8'h01; cfg_r1 = 8'h00;
    run_seq(30);
    chk(ready, "R10 completes despite start", ready, 1);
    chk(warm_n == 10 && cmd0_n == 1, "R10 start while busy ignored", warm_n, 10);
    run_seq(0);
    chk(ready && warm_n == 10 && cmd1_n == 2, "R10 restart from ready", cmd1_n, 2);
  endtask

  initial begin
    #4000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset;
    t_basic;
    t_poll_edge;
    t_timeout;
    t_limit;
    t_errbits;
    t_busy_start;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule